// File: doc/BRIEF.md
# Security Violation Event Collector

This block gathers single-cycle illegal-access pulses from a set of source lines. There can be up to 256 lines, and the count is chosen at build time. Each line owns three bits, grouped 32 lines to a 32-bit bank:

- a sticky status flag;
- a mask bit that lets the flag reach the interrupt;
- a write-one-to-clear bit.

A global capture switch decides whether pulses are recorded at all. A single level-sensitive interrupt stays high while any recorded and unmasked flag remains.

Software uses a flat 32-bit register window. Writes take effect on the clock edge. Reads are combinational from the current address and have no side effects. Two read-only words describe the build: one gives the line count and an auxiliary field, the other gives the revision. The usual handler flow is:

1. Read a status bank and AND it with the mask bank.
2. Log the lines that are set.
3. Clear those lines by writing ones to the matching clear bank.
4. Repeat until the interrupt drops.

Top module: `sec_evt_collector`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all status, mask and capture-switch bits read 0 and irq_o is 0.
- R2: Line n belongs to bank n/32, bit n%32. There are ceil(NUM_LINES/32) banks. The mask banks sit at byte offset 0x000+4*i (read/write), the status banks at 0x040+4*i (read-only) and the clear banks at 0x080+4*i (write-only, read 0).
- R3: A pulse on evt_i sets its status bit at the next clock edge only while the capture switch (bit 0 of the word at 0x100) is 1. The bit is set whether or not the line's mask bit is set.
- R4: Writing a 1 to a clear-bank bit clears the matching status bit. Writing 0 to it changes nothing, and writes to the status banks are ignored.
- R5: When an event and a clear hit the same status bit in the same cycle, the bit ends up set. Other bits cleared in that write still clear.
- R6: irq_o is a level. It is 1 in every cycle in which some bank has a nonzero (status AND mask), and 0 otherwise.
- R7: Bits for lines at or above NUM_LINES always read 0, ignore writes to the mask, and never set.
- R8: The read-only word at 0x3F0 holds NUM_LINES in bits 7:0 (256 encodes as 0) and the CFG_AUX parameter in bits 18:16. The word at 0x3F4 holds REV_MINOR in bits 3:0 and REV_MAJOR in bits 7:4. All other bits of both words are 0, and writes to them are ignored.
- R9: Reads of unmapped or misaligned offsets return 0. This covers bank slots beyond the implemented count and bits 31:1 of the capture-switch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_LINES | One-cycle violation pulses, one per source line |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Level interrupt: any unmasked status bit set |

## Verification
Event capture and write-one-to-clear can both hit the same status word in one clock. The bench provokes this by first latching two lines. It then drives, in a single cycle, a new pulse on one of those lines together with a clear write that names both lines. It judges the result by reading the status bank back after that edge. Only the re-pulsed line may remain set, and the interrupt must stay high because that line is unmasked.

// File: rtl/sec_evt_pkg.sv
// Package: shared constants and types for the violation event collector.
// Assumes a 12-bit byte address window with 32-bit word-aligned registers.
package sec_evt_pkg;
    typedef logic [31:0] word_t;

    localparam int LINES_PER_BANK = 32;
    localparam int ADDR_W         = 12;
    localparam int MAX_BANKS      = 16;

    // Word index (byte address / 4) regions, in 16-word slots.
    localparam logic [5:0] SLOT_MASK  = 6'd0;   // 0x000
    localparam logic [5:0] SLOT_STAT  = 6'd1;   // 0x040
    localparam logic [5:0] SLOT_CLEAR = 6'd2;   // 0x080
    localparam logic [9:0] WORD_CTRL  = 10'd64;  // 0x100
    localparam logic [9:0] WORD_HWCFG = 10'd252; // 0x3F0
    localparam logic [9:0] WORD_REV   = 10'd253; // 0x3F4
endpackage

// File: rtl/sec_evt_bank.sv
// Module: one bank of 32 violation lines (status flags plus mask bits).
// Assumes the write strobes come from the address decoder. Bits at or above
// VALID_BITS are tied to 0. A new event beats a simultaneous clear.
module sec_evt_bank
    import sec_evt_pkg::*;
#(
    parameter int VALID_BITS = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cap_en,
    input  word_t evt,
    input  logic  mask_we,
    input  logic  clr_we,
    input  word_t wdata,
    output word_t status,
    output word_t mask
);
    localparam word_t VALID_MASK = (VALID_BITS >= 32) ? '1
                                 : word_t'((64'd1 << VALID_BITS) - 64'd1);

    word_t set_bits;
    word_t clr_bits;

    // Purpose: form the set and clear vectors for this cycle.
    always_comb begin
        set_bits = cap_en ? evt : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    // Purpose: update the sticky flags (set wins over clear) and the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= ((status & ~clr_bits) | set_bits) & VALID_MASK;
            if (mask_we) begin
                mask <= wdata & VALID_MASK;
            end
        end
    end
endmodule

// File: rtl/sec_evt_regif.sv
// Module: address decoder and read multiplexer for the collector window.
// Assumes word-aligned accesses. A misaligned or unmapped address selects
// nothing and reads 0. Reads are combinational and have no side effects.
module sec_evt_regif
    import sec_evt_pkg::*;
#(
    parameter int          NUM_BANKS = 2,
    parameter int          NUM_LINES = 40,
    parameter logic [2:0]  CFG_AUX   = 3'd5,
    parameter logic [3:0]  REV_MAJOR = 4'd2,
    parameter logic [3:0]  REV_MINOR = 4'd1
) (
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  word_t                         bus_wdata,
    input  logic [NUM_BANKS-1:0][31:0]    sts,
    input  logic [NUM_BANKS-1:0][31:0]    msk,
    input  logic                          cap_en,
    output logic [NUM_BANKS-1:0]          mask_we,
    output logic [NUM_BANKS-1:0]          clr_we,
    output logic                          ctrl_we,
    output word_t                         bus_rdata
);
    logic       aligned;
    logic [9:0] word;
    logic [5:0] slot;
    logic [3:0] idx;

    // Purpose: split the byte address into word, slot and bank index.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        word    = bus_addr[ADDR_W-1:2];
        slot    = word[9:4];
        idx     = word[3:0];
    end

    // Purpose: raise per-bank write strobes for the mask and clear arrays.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            mask_we[b] = bus_wr && aligned && (slot == SLOT_MASK)  && (idx == 4'(b));
            clr_we[b]  = bus_wr && aligned && (slot == SLOT_CLEAR) && (idx == 4'(b));
        end
        ctrl_we = bus_wr && aligned && (word == WORD_CTRL);
    end

    // Purpose: select the read word; unmapped space returns zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (word == WORD_CTRL) begin
                bus_rdata = {31'd0, cap_en};
            end else if (word == WORD_HWCFG) begin
                bus_rdata = {13'd0, CFG_AUX, 8'd0, 8'(NUM_LINES)};
            end else if (word == WORD_REV) begin
                bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (idx == 4'(b)) begin
                        if (slot == SLOT_MASK) bus_rdata = msk[b];
                        if (slot == SLOT_STAT) bus_rdata = sts[b];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sec_evt_collector.sv
// Module: top of the violation event collector.
// Latches event pulses into banked sticky flags while capture is enabled.
// Masks them into one level interrupt. Exposes everything through a flat
// 32-bit register window. Assumes evt_i is synchronous to clk.
module sec_evt_collector
    import sec_evt_pkg::*;
#(
    parameter int          NUM_LINES = 40,
    parameter logic [2:0]  CFG_AUX   = 3'd5,
    parameter logic [3:0]  REV_MAJOR = 4'd2,
    parameter logic [3:0]  REV_MINOR = 4'd1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  evt_i,
    input  logic                  bus_wr,
    input  logic [11:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  irq_o
);
    localparam int NUM_BANKS = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK;
    localparam int TOTAL     = NUM_BANKS * LINES_PER_BANK;

    logic [NUM_BANKS-1:0][31:0] sts;
    logic [NUM_BANKS-1:0][31:0] msk;
    logic [NUM_BANKS-1:0]       mask_we;
    logic [NUM_BANKS-1:0]       clr_we;
    logic                       ctrl_we;
    logic                       cap_en;
    logic [TOTAL-1:0]           evt_pad;
    logic [TOTAL-1:0]           sts_flat;
    logic [TOTAL-1:0]           ena_flat;

    // Purpose: widen the event vector to whole banks and flatten the arrays.
    always_comb begin
        evt_pad  = TOTAL'(evt_i);
        sts_flat = sts;
        ena_flat = msk;
    end

    // Purpose: hold the global capture switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en <= 1'b0;
        end else if (ctrl_we) begin
            cap_en <= bus_wdata[0];
        end
    end

    sec_evt_regif #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_LINES (NUM_LINES),
        .CFG_AUX   (CFG_AUX),
        .REV_MAJOR (REV_MAJOR),
        .REV_MINOR (REV_MINOR)
    ) u_regif (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sts       (sts),
        .msk       (msk),
        .cap_en    (cap_en),
        .mask_we   (mask_we),
        .clr_we    (clr_we),
        .ctrl_we   (ctrl_we),
        .bus_rdata (bus_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int VB = (b < NUM_BANKS - 1) ? 32 : NUM_LINES - 32 * (NUM_BANKS - 1);
        sec_evt_bank #(.VALID_BITS(VB)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (cap_en),
            .evt     (evt_pad[b*32 +: 32]),
            .mask_we (mask_we[b]),
            .clr_we  (clr_we[b]),
            .wdata   (bus_wdata),
            .status  (sts[b]),
            .mask    (msk[b])
        );
    end

    // Purpose: reduce unmasked flags of all banks into the level interrupt.
    always_comb begin
        irq_o = |(sts_flat & ena_flat);
    end
endmodule

// File: rtl/sec_evt_collector_chk.sv
// Module: property checker for sec_evt_collector, attached by bind below.
// Assumes it sees the flattened status and mask vectors and the capture switch.
module sec_evt_collector_chk #(
    parameter int NUM_LINES = 40,
    parameter int TOTAL     = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] evt_i,
    input logic                 bus_wr,
    input logic                 irq_o,
    input logic                 cap_en,
    input logic [TOTAL-1:0]     sts_flat,
    input logic [TOTAL-1:0]     ena_flat
);
    localparam logic [TOTAL-1:0] VALID = TOTAL'(({{(TOTAL){1'b0}}, 1'b1} << NUM_LINES) - 1);

    logic past_valid;

    // Purpose: mark that at least one clock edge has been seen.
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !$past(rst_n) |-> (sts_flat == '0 && ena_flat == '0 && !cap_en && !irq_o));

    assert_capture_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rst_n) && !$past(cap_en) |-> ((sts_flat & ~$past(sts_flat)) == '0));

    assert_no_write_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rst_n) && !$past(bus_wr) |-> (($past(sts_flat) & ~sts_flat) == '0));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rst_n) && $past(cap_en) |-> ((TOTAL'($past(evt_i)) & ~sts_flat) == '0));

    assert_irq_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rst_n) && $past(irq_o) && !$past(bus_wr) |-> irq_o);

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (((sts_flat | ena_flat) & ~VALID) == '0));
endmodule

bind sec_evt_collector sec_evt_collector_chk #(
    .NUM_LINES (NUM_LINES),
    .TOTAL     (TOTAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .bus_wr   (bus_wr),
    .irq_o    (irq_o),
    .cap_en   (cap_en),
    .sts_flat (sts_flat),
    .ena_flat (ena_flat)
);

// File: tb/sim_sec_evt_collector.sv
module sim_sec_evt_collector;
    localparam int N = 40;

    typedef struct packed {
        logic [1:0]   kind;   // 0 read-check, 1 write, 2 event pulse
        logic [11:0]  addr;
        logic [31:0]  data;   // write data or expected read data
        logic [N-1:0] evt;
        logic         irq;    // expected irq after the step
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 12'h100, 32'h0,        40'h0,          1'b0, 4'd1}, // R1 switch off
        '{2'd0, 12'h040, 32'h0,        40'h0,          1'b0, 4'd1}, // R1 status clear
        '{2'd2, 12'h000, 32'h0,        40'h8,          1'b0, 4'd3}, // R3 pulse while off
        '{2'd0, 12'h040, 32'h0,        40'h0,          1'b0, 4'd3}, // R3 not captured
        '{2'd1, 12'h100, 32'hFFFFFFFF, 40'h0,          1'b0, 4'd3},
        '{2'd0, 12'h100, 32'h1,        40'h0,          1'b0, 4'd9}, // R9 upper bits 0
        '{2'd2, 12'h000, 32'h0,        40'h8_0000_0008, 1'b0, 4'd3}, // R3 capture, masked
        '{2'd0, 12'h040, 32'h8,        40'h0,          1'b0, 4'd3}, // R3 latched unmasked
        '{2'd0, 12'h044, 32'h8,        40'h0,          1'b0, 4'd2}, // R2 line 35 -> bank1 bit3
        '{2'd1, 12'h000, 32'h8,        40'h0,          1'b1, 4'd6}, // R6 unmask -> irq
        '{2'd0, 12'h000, 32'h8,        40'h0,          1'b1, 4'd2},
        '{2'd1, 12'h080, 32'h0,        40'h0,          1'b1, 4'd4}, // R4 zero clear
        '{2'd0, 12'h040, 32'h8,        40'h0,          1'b1, 4'd4},
        '{2'd1, 12'h040, 32'h0,        40'h0,          1'b1, 4'd4}, // R4 status write ignored
        '{2'd0, 12'h040, 32'h8,        40'h0,          1'b1, 4'd4},
        '{2'd1, 12'h080, 32'h8,        40'h0,          1'b0, 4'd4}, // R4 W1C
        '{2'd0, 12'h040, 32'h0,        40'h0,          1'b0, 4'd4},
        '{2'd0, 12'h044, 32'h8,        40'h0,          1'b0, 4'd6}, // R6 bank1 masked
        '{2'd1, 12'h004, 32'hFFFFFFFF, 40'h0,          1'b1, 4'd6},
        '{2'd0, 12'h004, 32'hFF,       40'h0,          1'b1, 4'd7}, // R7 upper mask bits 0
        '{2'd1, 12'h084, 32'hFFFFFFFF, 40'h0,          1'b0, 4'd4},
        '{2'd0, 12'h044, 32'h0,        40'h0,          1'b0, 4'd4},
        '{2'd0, 12'h3F0, 32'h00050028, 40'h0,          1'b0, 4'd8}, // R8 cfg
        '{2'd0, 12'h3F4, 32'h21,       40'h0,          1'b0, 4'd8}, // R8 revision
        '{2'd1, 12'h3F0, 32'hFFFFFFFF, 40'h0,          1'b0, 4'd8},
        '{2'd0, 12'h3F0, 32'h00050028, 40'h0,          1'b0, 4'd8}, // R8 read-only
        '{2'd0, 12'h048, 32'h0,        40'h0,          1'b0, 4'd9}, // R9 absent bank
        '{2'd0, 12'h008, 32'h0,        40'h0,          1'b0, 4'd9},
        '{2'd0, 12'h201, 32'h0,        40'h0,          1'b0, 4'd9}, // R9 misaligned/unmapped
        '{2'd2, 12'h000, 32'h0,        40'h80_0000_0000, 1'b1, 4'd7}, // R7 top line 39
        '{2'd0, 12'h044, 32'h80,       40'h0,          1'b1, 4'd7},
        '{2'd1, 12'h084, 32'h80,       40'h0,          1'b0, 4'd4}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_o;
    int           checks = 0;
    int           failures = 0;

    always #2.5 clk = ~clk;

    sec_evt_collector #(.NUM_LINES(N), .CFG_AUX(3'd5), .REV_MAJOR(4'd2), .REV_MINOR(4'd1)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d step%0d", VECS[i].req, i);
            case (VECS[i].kind)
                2'd1: wr(VECS[i].addr, VECS[i].data);
                2'd2: pulse(VECS[i].evt);
                default: rd(tag, VECS[i].addr, VECS[i].data);
            endcase
            #1;
            check({tag, " irq"}, {31'd0, irq_o}, {31'd0, VECS[i].irq});
        end

        // R6: unmasked flag keeps the level high across idle cycles.
        wr(12'h000, 32'h1);
        pulse(40'h1);
        repeat (5) @(negedge clk);
        #1;
        check("R6 irq held", {31'd0, irq_o}, 32'd1);
        rd("R6 status", 12'h040, 32'h1);

        // R5: event on line 0 and clear of lines 0 and 1 in the same cycle.
        pulse(40'h2);
        rd("R5 pre", 12'h040, 32'h3);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h080; bus_wdata = 32'h3; evt_i = 40'h1;
        @(negedge clk);
        bus_wr = 1'b0; evt_i = '0;
        rd("R5 event wins", 12'h040, 32'h1);
        #1;
        check("R5 irq", {31'd0, irq_o}, 32'd1);

        // R1: synchronous reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1 ctrl", 12'h100, 32'h0);
        rd("R1 status", 12'h040, 32'h0);
        rd("R1 mask", 12'h004, 32'h0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule